// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a watchdog timer that software controls through a small 32-bit register bus. Software programs a reload count and then sets the enable bit. The counter loads the reload count and counts down by one on every selected tick. The tick is either every peripheral clock cycle (24 MHz) or a 1 MHz tick, which a divide-by-24 prescaler makes from the same clock. Software keeps the system alive by writing a 16-bit key to the restart word. Any other value written there has no effect. When the count runs out, the block either raises a one-cycle reset request or, if the hold input is high, clears its own control word without asking for a reset. In both cases the countdown stops, so each expiry fires once.

A second register describes the reset output that logic outside this block will drive. Its low bits hold a pulse width, which every write replaces. Its polarity bit and its drive-type bit change only when the top byte of the written data is one of four key values. The bus has no back-pressure: a request is taken on the cycle it is valid. A read answers with `rd_valid` and `rd_data` one cycle later. Control and status pins are plain levels.

Top module: `guard_timer`

## Requirements
- R1: After reset, the live count and the reload register both read 0x03EF1480, the control word reads 0, the output-config word reads 0x000000FF, and `reset_req` is low.
- R2: Word map by byte address: 0x00 live count (read-only; writes ignored), 0x04 reload, 0x08 restart (reads return 0), 0x0C control, 0x18 output config. Any other address reads 0, and writes to it change nothing. Read data appears with `rd_valid` on the cycle after the request.
- R3: A write to 0x08 whose low 16 bits are 0x4755 copies the reload value into the counter. If enable is set, the countdown also restarts. Any other value changes nothing.
- R4: Control bits are: bit0 enable, bit1 reset-system, bit2 interrupt, bit3 external, bit4 tick select, bit5 reset mode. A control write is stored only when its bit0 differs from the current enable. A write that sets enable loads the counter from the reload value and starts the countdown. A write that clears enable freezes the count. A write that leaves enable unchanged is ignored.
- R5: With bit4 = 0, the count drops by one every clock cycle. After a load of N (N ≥ 1), expiry happens on the Nth cycle after the load.
- R6: With bit4 = 1, the count drops once every 24 clock cycles. The prescaler restarts on every load, so expiry comes 24·N cycles after the load.
- R7: On expiry with `expiry_hold` low, `reset_req` is high for exactly one cycle. The count then stays at 0, with no further pulse, and the control word keeps its value.
- R8: On expiry with `expiry_hold` high, no reset request is raised and the control word is cleared to 0.
- R9: In a write to 0x18, top byte 0xA5 sets bit31 and 0x5A clears it. Top byte 0xA8 sets bit30 and 0x8A clears it. Any other top byte leaves bits 31 and 30 unchanged.
- R10: Every write to 0x18 replaces the pulse-width field (bits 19:0 by default, a parameter) with the written data. Bits 29:20 always read 0.
- R11: `reset_mode` shows control bit5 (0 = SoC reset, 1 = full-chip reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 24 MHz tick source |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| expiry_hold | input | 1 | When high at expiry, the block disables itself instead of requesting a reset |
| reset_req | output | 1 | One-cycle reset request on expiry |
| reset_mode | output | 1 | Reset mode from control bit5 |

## Verification
Register writes take effect on the clock edge that samples them. Read data is due one edge later, so the monitor pops an expected value at the falling edge after each read request. After the write that loads the counter, the bench samples at falling edges only. With the per-cycle tick, the reset pulse is due at the Nth falling edge after the load. With the slow tick, it is due at the 24·Nth falling edge. The bench checks `reset_req` at every one of those falling edges, so a pulse one cycle early, one cycle late or two cycles long is caught. When the countdown is frozen, the live count is read twice at falling edges well away from the stopping edge.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int DATA_W = 32;

  // word indices (byte address / 4)
  localparam int IDX_COUNT  = 0;
  localparam int IDX_RELOAD = 1;
  localparam int IDX_KICK   = 2;
  localparam int IDX_CTRL   = 3;
  localparam int IDX_OUTCFG = 6;

  localparam logic [15:0] KICK_KEY    = 16'h4755;
  localparam logic [7:0]  POL_HI_KEY  = 8'hA5;
  localparam logic [7:0]  POL_LO_KEY  = 8'h5A;
  localparam logic [7:0]  DRV_PP_KEY  = 8'hA8;
  localparam logic [7:0]  DRV_OD_KEY  = 8'h8A;

  typedef struct packed {
    logic full_chip;
    logic slow_tick;
    logic ext_sig;
    logic irq_en;
    logic sys_rst;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/gtmr_tick.sv
module gtmr_tick #(
  parameter int PRESCALE = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sel_slow,
  output logic tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap = (pre_q == PRE_LAST);
  assign tick = sel_slow ? wrap : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (clear)   pre_q <= '0;
    else if (wrap)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R6
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);

  // R6
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0));
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] COUNT_INIT = CNT_W'(32'h03EF1480)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             start,
  input  logic             halt,
  input  logic             tick,
  input  logic             hold,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             hold_clear,
  output logic             reset_req
);
  logic             running_q;
  logic [CNT_W-1:0] count_q;
  logic             step;
  logic             last;
  logic             expire;

  assign step       = running_q && tick && !load && !halt;
  assign last       = (count_q <= CNT_W'(1));
  assign expire     = step && last;
  assign hold_clear = expire && hold;
  assign count      = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= COUNT_INIT;
      running_q <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= expire && !hold;
      if (load) begin
        count_q   <= reload_val;
        running_q <= start;
      end else if (halt) begin
        running_q <= 1'b0;
      end else if (step) begin
        count_q <= last ? '0 : count_q - 1'b1;
        if (last) running_q <= 1'b0;
      end
    end
  end

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R7
  stopped_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (!running_q && count_q == '0));

  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count_q <= $past(count_q)));
endmodule

// File: rtl/gtmr_regs.sv
module gtmr_regs
  import gtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PW_W   = 20,
  parameter int ADDR_W = 8,
  parameter logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(32'h03EF1480)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  count_val,
  input  logic              hold_clear,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload_val,
  output logic              load,
  output logic              start,
  output logic              halt
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] W_COUNT  = IDX_W'(IDX_COUNT);
  localparam logic [IDX_W-1:0] W_RELOAD = IDX_W'(IDX_RELOAD);
  localparam logic [IDX_W-1:0] W_KICK   = IDX_W'(IDX_KICK);
  localparam logic [IDX_W-1:0] W_CTRL   = IDX_W'(IDX_CTRL);
  localparam logic [IDX_W-1:0] W_OUTCFG = IDX_W'(IDX_OUTCFG);
  localparam int GAP_W = 30 - PW_W;

  logic [IDX_W-1:0] idx;
  logic             wr_hit;
  logic             kick_ok;
  logic             ctrl_wr;
  logic             cfg_wr;
  logic [7:0]       top_byte;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             pol_q;
  logic             drv_q;
  logic [PW_W-1:0]  pw_q;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_addr_bits;

  assign unused_addr_bits = ^req_addr[1:0];
  assign idx      = req_addr[ADDR_W-1:2];
  assign wr_hit   = req_valid && req_write;
  assign top_byte = req_wdata[31:24];
  assign kick_ok  = wr_hit && (idx == W_KICK) && (req_wdata[15:0] == KICK_KEY);
  assign ctrl_wr  = wr_hit && (idx == W_CTRL) && (req_wdata[0] != ctrl_q.enable);
  assign cfg_wr   = wr_hit && (idx == W_OUTCFG);

  assign load  = kick_ok || (ctrl_wr && req_wdata[0]);
  assign start = (ctrl_wr && req_wdata[0]) || (kick_ok && ctrl_q.enable);
  assign halt  = ctrl_wr && !req_wdata[0];

  assign ctrl       = ctrl_q;
  assign reload_val = reload_q;

  // control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (ctrl_wr)    ctrl_q <= ctrl_t'(req_wdata[5:0]);
    else if (hold_clear) ctrl_q <= '0;
  end

  // reload word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= RELOAD_INIT;
    else if (wr_hit && idx == W_RELOAD) reload_q <= req_wdata[CNT_W-1:0];
  end

  // output-config word: keyed polarity / drive bits, plain pulse width
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      drv_q <= 1'b0;
      pw_q  <= PW_W'(8'hFF);
    end else if (cfg_wr) begin
      pw_q <= req_wdata[PW_W-1:0];
      case (top_byte)
        POL_HI_KEY: pol_q <= 1'b1;
        POL_LO_KEY: pol_q <= 1'b0;
        DRV_PP_KEY: drv_q <= 1'b1;
        DRV_OD_KEY: drv_q <= 1'b0;
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    case (idx)
      W_COUNT:  rd_mux = DATA_W'(count_val);
      W_RELOAD: rd_mux = DATA_W'(reload_q);
      W_CTRL:   rd_mux = DATA_W'(ctrl_q);
      W_OUTCFG: rd_mux = {pol_q, drv_q, {GAP_W{1'b0}}, pw_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= rd_mux;
    end
  end

  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_clear && !ctrl_wr) |=> !ctrl_q.enable);

  // R4
  same_enable_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && idx == W_CTRL && req_wdata[0] == ctrl_q.enable && !hold_clear)
      |=> $stable(ctrl_q));

  // R9
  pol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && top_byte == POL_HI_KEY) |=> pol_q);

  // R9
  drv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && top_byte != DRV_PP_KEY && top_byte != DRV_OD_KEY) |=> $stable(drv_q));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gtmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PW_W     = 20,
  parameter int ADDR_W   = 8,
  parameter int PRESCALE = 24,
  parameter logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(32'h03EF1480)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              expiry_hold,
  output logic              reset_req,
  output logic              reset_mode
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count;
  logic             load;
  logic             start;
  logic             halt;
  logic             tick;
  logic             hold_clear;

  gtmr_regs #(
    .CNT_W(CNT_W), .PW_W(PW_W), .ADDR_W(ADDR_W), .RELOAD_INIT(RELOAD_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .count_val(count), .hold_clear(hold_clear),
    .ctrl(ctrl), .reload_val(reload_val),
    .load(load), .start(start), .halt(halt)
  );

  gtmr_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(load),
    .sel_slow(ctrl.slow_tick), .tick(tick)
  );

  gtmr_count #(.CNT_W(CNT_W), .COUNT_INIT(RELOAD_INIT)) u_count (
    .clk(clk), .rst_n(rst_n),
    .load(load), .start(start), .halt(halt),
    .tick(tick), .hold(expiry_hold),
    .reload_val(reload_val), .count(count),
    .hold_clear(hold_clear), .reset_req(reset_req)
  );

  assign reset_mode = ctrl.full_chip;

  // R3
  key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(reload_val)));

  // R8
  hold_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clear |=> !reset_req);
endmodule

// File: tb/guard_timer_bench.sv
`timescale 1ns/1ps
module guard_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        expiry_hold = 1'b0;
  logic        reset_req;
  logic        reset_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  guard_timer u_guard_timer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .expiry_hold(expiry_hold),
    .reset_req(reset_req), .reset_mode(reset_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // driver: push expectation, issue read
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pop and compare when read data arrives
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // pulse due at the n-th falling edge after the loading write returns
  task automatic expect_pulse(input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      check(tag, {31'b0, reset_req}, {31'b0, (i == n)});
    end
    @(negedge clk);
    check(tag, {31'b0, reset_req}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 reset_req", {31'b0, reset_req}, 32'd0);
    check("R11 reset_mode", {31'b0, reset_mode}, 32'd0);
    rd(8'h00, 32'h03EF1480, "R1 count");
    rd(8'h04, 32'h03EF1480, "R1 reload");
    rd(8'h0C, 32'h0, "R1 ctrl");
    rd(8'h18, 32'h000000FF, "R1 outcfg");

    // R2 map
    rd(8'h08, 32'h0, "R2 restart reads 0");
    rd(8'h1C, 32'h0, "R2 unmapped read");
    wr(8'h00, 32'h1234);
    rd(8'h00, 32'h03EF1480, "R2 count read-only");
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h04, 32'h03EF1480, "R2 unmapped write");

    // R3 key while disabled
    wr(8'h04, 32'h55);
    wr(8'h08, 32'h4756);
    rd(8'h00, 32'h03EF1480, "R3 bad key");
    wr(8'h08, 32'hABCD4755);
    rd(8'h00, 32'h55, "R3 good key");
    check("R3 no run", {31'b0, reset_req}, 32'd0);

    // R5 / R7 fast tick expiry
    wr(8'h04, 32'd10);
    wr(8'h0C, 32'h1);
    expect_pulse(10, "R5 fast expiry");
    rd(8'h00, 32'h0, "R7 count at 0");
    rd(8'h0C, 32'h1, "R7 ctrl kept");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 no second pulse", {31'b0, reset_req}, 32'd0);
    end

    // R4 / R11 enable-change filter
    wr(8'h0C, 32'h21);
    rd(8'h0C, 32'h1, "R4 same enable ignored");
    check("R11 mode low", {31'b0, reset_mode}, 32'd0);
    wr(8'h0C, 32'h20);
    rd(8'h0C, 32'h20, "R4 disable stored");
    check("R11 mode high", {31'b0, reset_mode}, 32'd1);

    // R4 start then stop freezes count
    wr(8'h04, 32'd100);
    wr(8'h0C, 32'h1);
    repeat (5) @(negedge clk);
    wr(8'h0C, 32'h0);
    rd(8'h00, 32'd94, "R4 frozen count");
    rd(8'h00, 32'd94, "R4 still frozen");

    // R6 slow tick
    wr(8'h04, 32'd2);
    wr(8'h0C, 32'h11);
    expect_pulse(48, "R6 slow expiry");

    // R8 hold at expiry
    wr(8'h0C, 32'h0);
    expiry_hold = 1'b1;
    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 no request", {31'b0, reset_req}, 32'd0);
    end
    rd(8'h0C, 32'h0, "R8 ctrl cleared");
    expiry_hold = 1'b0;

    // R3 restart while running
    wr(8'h04, 32'd6);
    wr(8'h0C, 32'h1);
    repeat (3) @(negedge clk);
    wr(8'h08, 32'h0000_4755);
    expect_pulse(6, "R3 restart reload");

    // R9 / R10 output config
    wr(8'h18, 32'hA500_0123);
    rd(8'h18, 32'h8000_0123, "R9 pol set");
    wr(8'h18, 32'hA80F_FFFF);
    rd(8'h18, 32'hC00F_FFFF, "R9 drv set");
    wr(8'h18, 32'h5A00_0000);
    rd(8'h18, 32'h4000_0000, "R9 pol clear");
    wr(8'h18, 32'h8A00_0007);
    rd(8'h18, 32'h0000_0007, "R9 drv clear");
    wr(8'h18, 32'hC3FF_FFFF);
    rd(8'h18, 32'h000F_FFFF, "R10 width replaced, gap zero");
    wr(8'h18, 32'hA5F0_0000);
    rd(8'h18, 32'h8000_0000, "R10 width cleared");

    repeat (2) @(negedge clk);
    check("R2 all reads answered", exp_q.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule